// File: doc/BRIEF.md
# Periodic Multi-Owner DMA Transfer Table

This block moves blocks of words from one memory region to another on behalf of several processor cores. Each core programs its own slots in a shared table of transfer descriptors through a simple write-only configuration port. A descriptor carries a source word address, a destination word address, a word count, a reload period in ticks, an owner identifier and an enable bit. A typical use is to copy a fixed-size chunk of freshly sampled data into a core's private memory once every sampling window.

Enabled descriptors become ready at once when enabled and, if they have a nonzero period, again each time their tick counter expires. A round-robin picker hands one ready descriptor at a time to a single transfer engine. The engine copies the words one at a time over a generic request/grant memory port with a separate read-data strobe: it issues one read, waits for its data, then writes that word. When a descriptor finishes, the interrupt bit of its owner is raised and stays high until software clears it.

Top module: `dma_xfer_table`

## Requirements
- R1: After reset, `irq` is all zero, `mem_req` is low and `cfg_ack` is low.
- R2: Every cycle with `cfg_req` high is answered by `cfg_ack` high in the next cycle, and only then; `cfg_err` is only high together with `cfg_ack`. Field codes on `cfg_field`: 0 source address, 1 destination address, 2 word count, 3 period, 4 control (`cfg_wdata[0]` enable, `cfg_wdata[OWN_W:1]` owner), 7 interrupt clear (`cfg_idx` ignored); codes 5 and 6 have no effect.
- R3: A descriptor moves exactly its word count of words, reading source addresses and writing destination addresses in ascending order, with no write outside the destination range. A descriptor with period 0 runs once per enable and is then disabled, so later ticks do not run it again.
- R4: A descriptor with word count 0 completes and raises its owner's interrupt without any memory write.
- R5: On completion, bit `owner` of `irq` is set; a field-7 write clears the bits that are 1 in `cfg_wdata` and leaves the others unchanged; an interrupt bit never falls without such a write.
- R6: A write to any field of the descriptor that the engine is serving returns `cfg_err` = 1 and leaves the descriptor unchanged; writes to other descriptors return `cfg_err` = 0.
- R7: When several descriptors are ready, they are served one at a time, starting from the slot after the one last granted and wrapping around.
- R8: An enabled descriptor with period P > 0 becomes ready again on every P-th `tick` pulse after it is enabled; disabling it stops further runs.
- R9: While `mem_req` is high and `mem_gnt` low, `mem_addr`, `mem_we` and `mem_wdata` hold; no request is raised while a granted read still awaits `mem_rvalid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tick | input | 1 | Period time base, one pulse per tick |
| cfg_req | input | 1 | Configuration write strobe |
| cfg_idx | input | IDX_W | Descriptor slot to write |
| cfg_field | input | 3 | Field code (see R2) |
| cfg_wdata | input | DATA_W | Write data |
| cfg_ack | output | 1 | Write response, one cycle after the strobe |
| cfg_err | output | 1 | Write rejected because the slot is in service |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | 1 write, 0 read |
| mem_addr | output | ADDR_W | Word address |
| mem_wdata | output | DATA_W | Write data |
| mem_gnt | input | 1 | Request accepted this cycle |
| mem_rvalid | input | 1 | Read data valid |
| mem_rdata | input | DATA_W | Read data |
| irq | output | N_OWN | Per-owner completion flags |

## Verification
The memory-port assertions assume that the responder raises `mem_rvalid` exactly once for each accepted read and never without an outstanding read; the bench responder returns data one or two cycles after each read grant and drives no strobe otherwise. The interrupt assertion assumes that only field-7 writes are meant to clear bits, which the bench respects by clearing through that code alone. Grant timing on the memory side is randomized from a fixed seed, so request holding is exercised with random stall lengths, while descriptor contents mix random values with directed cases for zero length, locking, ordering and period reload.

// File: rtl/dma_xfer_pkg.sv
package dma_xfer_pkg;

    localparam logic [2:0] FLD_SRC    = 3'd0;
    localparam logic [2:0] FLD_DST    = 3'd1;
    localparam logic [2:0] FLD_CNT    = 3'd2;
    localparam logic [2:0] FLD_PER    = 3'd3;
    localparam logic [2:0] FLD_CTRL   = 3'd4;
    localparam logic [2:0] FLD_IRQCLR = 3'd7;

    typedef enum logic [2:0] {
        ENG_IDLE,
        ENG_RD,
        ENG_RWAIT,
        ENG_WR,
        ENG_DONE
    } eng_state_e;

endpackage

// File: rtl/dma_xfer_slots.sv
module dma_xfer_slots
    import dma_xfer_pkg::*;
#(
    parameter int N_ENT  = 8,
    parameter int ADDR_W = 16,
    parameter int DATA_W = 32,
    parameter int CNT_W  = 8,
    parameter int PER_W  = 12,
    parameter int OWN_W  = 2,
    localparam int IDX_W = $clog2(N_ENT)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [2:0]        wr_field,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              lock_vld,
    input  logic [IDX_W-1:0]  lock_idx,
    input  logic              take,
    input  logic [IDX_W-1:0]  take_idx,
    input  logic              fin,
    input  logic [IDX_W-1:0]  fin_idx,
    output logic              wr_err,
    output logic [N_ENT-1:0]  ready,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic [ADDR_W-1:0] rd_src,
    output logic [ADDR_W-1:0] rd_dst,
    output logic [CNT_W-1:0]  rd_cnt,
    output logic [OWN_W-1:0]  rd_own
);

    typedef struct packed {
        logic              vld;
        logic              pend;
        logic [OWN_W-1:0]  own;
        logic [ADDR_W-1:0] src;
        logic [ADDR_W-1:0] dst;
        logic [CNT_W-1:0]  cnt;
        logic [PER_W-1:0]  per;
        logic [PER_W-1:0]  tmr;
    } slot_t;

    slot_t [N_ENT-1:0] slot_d, slot_q;
    logic              wr_hit;

    assign wr_hit = wr_en && (wr_field != FLD_IRQCLR);
    assign wr_err = wr_hit && lock_vld && (wr_idx == lock_idx);

    always_comb begin
        slot_d = slot_q;
        for (int i = 0; i < N_ENT; i++) begin
            if (take && (take_idx == IDX_W'(i))) begin
                slot_d[i].pend = 1'b0;
            end
            if (tick && slot_q[i].vld && (slot_q[i].per != '0)) begin
                if (slot_q[i].tmr <= PER_W'(1)) begin
                    slot_d[i].pend = 1'b1;
                    slot_d[i].tmr  = slot_q[i].per;
                end else begin
                    slot_d[i].tmr  = slot_q[i].tmr - PER_W'(1);
                end
            end
            if (fin && (fin_idx == IDX_W'(i)) && (slot_q[i].per == '0)) begin
                slot_d[i].vld  = 1'b0;
            end
            if (wr_hit && !wr_err && (wr_idx == IDX_W'(i))) begin
                case (wr_field)
                    FLD_SRC: slot_d[i].src = wr_data[ADDR_W-1:0];
                    FLD_DST: slot_d[i].dst = wr_data[ADDR_W-1:0];
                    FLD_CNT: slot_d[i].cnt = wr_data[CNT_W-1:0];
                    FLD_PER: slot_d[i].per = wr_data[PER_W-1:0];
                    FLD_CTRL: begin
                        slot_d[i].vld  = wr_data[0];
                        slot_d[i].pend = wr_data[0];
                        slot_d[i].own  = wr_data[OWN_W:1];
                        slot_d[i].tmr  = slot_q[i].per;
                    end
                    default: ;
                endcase
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            slot_q <= '0;
        end else begin
            slot_q <= slot_d;
        end
    end

    for (genvar g = 0; g < N_ENT; g++) begin : g_ready
        assign ready[g] = slot_q[g].vld && slot_q[g].pend;
    end

    assign rd_src = slot_q[rd_idx].src;
    assign rd_dst = slot_q[rd_idx].dst;
    assign rd_cnt = slot_q[rd_idx].cnt;
    assign rd_own = slot_q[rd_idx].own;

endmodule

// File: rtl/dma_xfer_rr.sv
module dma_xfer_rr #(
    parameter int N_ENT  = 8,
    localparam int IDX_W = $clog2(N_ENT)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_ENT-1:0] req,
    input  logic             take,
    output logic             any,
    output logic [IDX_W-1:0] pick
);

    logic [IDX_W-1:0] ptr_d, ptr_q;

    always_comb begin
        any  = 1'b0;
        pick = '0;
        for (int k = N_ENT - 1; k >= 0; k--) begin
            int j;
            j = int'(ptr_q) + k;
            if (j >= N_ENT) j = j - N_ENT;
            if (req[j]) begin
                any  = 1'b1;
                pick = IDX_W'(j);
            end
        end
        ptr_d = ptr_q;
        if (take) begin
            ptr_d = (int'(pick) == N_ENT - 1) ? '0 : pick + IDX_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ptr_q <= '0;
        end else begin
            ptr_q <= ptr_d;
        end
    end

endmodule

// File: rtl/dma_xfer_engine.sv
module dma_xfer_engine
    import dma_xfer_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 32,
    parameter int CNT_W  = 8,
    parameter int OWN_W  = 2,
    parameter int IDX_W  = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [IDX_W-1:0]  start_idx,
    input  logic [ADDR_W-1:0] start_src,
    input  logic [ADDR_W-1:0] start_dst,
    input  logic [CNT_W-1:0]  start_cnt,
    input  logic [OWN_W-1:0]  start_own,
    output logic              busy,
    output logic [IDX_W-1:0]  cur_idx,
    output logic              fin,
    output logic [OWN_W-1:0]  fin_own,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic              mem_gnt,
    input  logic              mem_rvalid,
    input  logic [DATA_W-1:0] mem_rdata
);

    typedef struct packed {
        eng_state_e        st;
        logic [IDX_W-1:0]  idx;
        logic [OWN_W-1:0]  own;
        logic [ADDR_W-1:0] src;
        logic [ADDR_W-1:0] dst;
        logic [CNT_W-1:0]  left;
        logic [DATA_W-1:0] word;
    } eng_t;

    eng_t e_d, e_q;

    always_comb begin
        e_d = e_q;
        case (e_q.st)
            ENG_IDLE: begin
                if (start) begin
                    e_d.idx  = start_idx;
                    e_d.own  = start_own;
                    e_d.src  = start_src;
                    e_d.dst  = start_dst;
                    e_d.left = start_cnt;
                    e_d.st   = (start_cnt == '0) ? ENG_DONE : ENG_RD;
                end
            end
            ENG_RD: begin
                if (mem_gnt) e_d.st = ENG_RWAIT;
            end
            ENG_RWAIT: begin
                if (mem_rvalid) begin
                    e_d.word = mem_rdata;
                    e_d.st   = ENG_WR;
                end
            end
            ENG_WR: begin
                if (mem_gnt) begin
                    e_d.src  = e_q.src + ADDR_W'(1);
                    e_d.dst  = e_q.dst + ADDR_W'(1);
                    e_d.left = e_q.left - CNT_W'(1);
                    e_d.st   = (e_q.left == CNT_W'(1)) ? ENG_DONE : ENG_RD;
                end
            end
            ENG_DONE: e_d.st = ENG_IDLE;
            default:  e_d.st = ENG_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            e_q    <= '0;
            e_q.st <= ENG_IDLE;
        end else begin
            e_q <= e_d;
        end
    end

    assign busy      = (e_q.st != ENG_IDLE);
    assign cur_idx   = e_q.idx;
    assign fin       = (e_q.st == ENG_DONE);
    assign fin_own   = e_q.own;
    assign mem_req   = (e_q.st == ENG_RD) || (e_q.st == ENG_WR);
    assign mem_we    = (e_q.st == ENG_WR);
    assign mem_addr  = (e_q.st == ENG_WR) ? e_q.dst : e_q.src;
    assign mem_wdata = e_q.word;

endmodule

// File: rtl/dma_xfer_table.sv
module dma_xfer_table
    import dma_xfer_pkg::*;
#(
    parameter int N_ENT  = 8,
    parameter int N_OWN  = 4,
    parameter int ADDR_W = 16,
    parameter int DATA_W = 32,
    parameter int CNT_W  = 8,
    parameter int PER_W  = 12,
    localparam int IDX_W = $clog2(N_ENT),
    localparam int OWN_W = $clog2(N_OWN)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              cfg_req,
    input  logic [IDX_W-1:0]  cfg_idx,
    input  logic [2:0]        cfg_field,
    input  logic [DATA_W-1:0] cfg_wdata,
    output logic              cfg_ack,
    output logic              cfg_err,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic              mem_gnt,
    input  logic              mem_rvalid,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic [N_OWN-1:0]  irq
);

    typedef struct packed {
        logic             ack;
        logic             err;
        logic [N_OWN-1:0] irq;
    } top_t;

    top_t t_d, t_q;

    logic [N_ENT-1:0]  ready;
    logic              pick_any, start, eng_busy, fin, wr_err, lock_vld;
    logic [IDX_W-1:0]  pick_idx, cur_idx, lock_idx;
    logic [ADDR_W-1:0] sel_src, sel_dst;
    logic [CNT_W-1:0]  sel_cnt;
    logic [OWN_W-1:0]  sel_own, fin_own;

    assign start    = pick_any && !eng_busy;
    assign lock_vld = eng_busy || start;
    assign lock_idx = eng_busy ? cur_idx : pick_idx;

    dma_xfer_slots #(
        .N_ENT(N_ENT), .ADDR_W(ADDR_W), .DATA_W(DATA_W),
        .CNT_W(CNT_W), .PER_W(PER_W), .OWN_W(OWN_W)
    ) u_slots (
        .clk(clk), .rst_n(rst_n), .tick(tick),
        .wr_en(cfg_req), .wr_idx(cfg_idx), .wr_field(cfg_field), .wr_data(cfg_wdata),
        .lock_vld(lock_vld), .lock_idx(lock_idx),
        .take(start), .take_idx(pick_idx),
        .fin(fin), .fin_idx(cur_idx),
        .wr_err(wr_err), .ready(ready),
        .rd_idx(pick_idx), .rd_src(sel_src), .rd_dst(sel_dst),
        .rd_cnt(sel_cnt), .rd_own(sel_own)
    );

    dma_xfer_rr #(.N_ENT(N_ENT)) u_rr (
        .clk(clk), .rst_n(rst_n), .req(ready), .take(start),
        .any(pick_any), .pick(pick_idx)
    );

    dma_xfer_engine #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W),
        .OWN_W(OWN_W), .IDX_W(IDX_W)
    ) u_eng (
        .clk(clk), .rst_n(rst_n),
        .start(start), .start_idx(pick_idx), .start_src(sel_src),
        .start_dst(sel_dst), .start_cnt(sel_cnt), .start_own(sel_own),
        .busy(eng_busy), .cur_idx(cur_idx), .fin(fin), .fin_own(fin_own),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_gnt(mem_gnt), .mem_rvalid(mem_rvalid),
        .mem_rdata(mem_rdata)
    );

    always_comb begin
        t_d     = t_q;
        t_d.ack = cfg_req;
        t_d.err = wr_err;
        if (cfg_req && (cfg_field == FLD_IRQCLR)) begin
            t_d.irq = t_q.irq & ~cfg_wdata[N_OWN-1:0];
        end
        if (fin) begin
            t_d.irq[fin_own] = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            t_q <= '0;
        end else begin
            t_q <= t_d;
        end
    end

    assign cfg_ack = t_q.ack;
    assign cfg_err = t_q.err;
    assign irq     = t_q.irq;

endmodule

// File: rtl/dma_xfer_table_chk.sv
module dma_xfer_table_chk #(
    parameter int N_OWN  = 4,
    parameter int ADDR_W = 16,
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cfg_req,
    input logic [2:0]        cfg_field,
    input logic              cfg_ack,
    input logic              cfg_err,
    input logic              mem_req,
    input logic              mem_we,
    input logic [ADDR_W-1:0] mem_addr,
    input logic [DATA_W-1:0] mem_wdata,
    input logic              mem_gnt,
    input logic              mem_rvalid,
    input logic [N_OWN-1:0]  irq
);

    logic rd_out_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_out_q <= 1'b0;
        end else if (mem_req && mem_gnt && !mem_we) begin
            rd_out_q <= 1'b1;
        end else if (mem_rvalid) begin
            rd_out_q <= 1'b0;
        end
    end

    a_r9_hold_request: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_gnt) |=> (mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata)));

    a_r9_one_read: assert property (@(posedge clk) disable iff (!rst_n)
        rd_out_q |-> !mem_req);

    a_r2_ack_follows: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_req |=> cfg_ack);

    a_r2_no_stray_ack: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_req |=> !cfg_ack);

    a_r2_err_with_ack: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_err |-> cfg_ack);

    a_r5_clear_by_write: assert property (@(posedge clk) disable iff (!rst_n)
        (|($past(irq) & ~irq)) |-> $past(cfg_req && (cfg_field == 3'd7)));

endmodule

bind dma_xfer_table dma_xfer_table_chk #(
    .N_OWN(N_OWN), .ADDR_W(ADDR_W), .DATA_W(DATA_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .cfg_req(cfg_req), .cfg_field(cfg_field),
    .cfg_ack(cfg_ack), .cfg_err(cfg_err), .mem_req(mem_req), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_gnt(mem_gnt),
    .mem_rvalid(mem_rvalid), .irq(irq)
);

// File: tb/dma_xfer_table_bench.sv
module dma_xfer_table_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick = 1'b0;
    logic        cfg_req = 1'b0;
    logic [2:0]  cfg_idx = '0;
    logic [2:0]  cfg_field = '0;
    logic [31:0] cfg_wdata = '0;
    logic        cfg_ack, cfg_err;
    logic        mem_req, mem_we;
    logic [15:0] mem_addr;
    logic [31:0] mem_wdata;
    logic        mem_gnt = 1'b0;
    logic        mem_rvalid = 1'b0;
    logic [31:0] mem_rdata = '0;
    logic [3:0]  irq;

    int checks = 0;
    int failures = 0;

    logic [31:0] mem [0:2047];
    logic [15:0] wlog [0:1023];
    int          wlog_n = 0;
    logic [15:0] rq_addr = '0;
    int          rq_cnt = 0;

    always #2 clk = ~clk;

    dma_xfer_table u_dma_xfer_table (
        .clk(clk), .rst_n(rst_n), .tick(tick),
        .cfg_req(cfg_req), .cfg_idx(cfg_idx), .cfg_field(cfg_field),
        .cfg_wdata(cfg_wdata), .cfg_ack(cfg_ack), .cfg_err(cfg_err),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_gnt(mem_gnt), .mem_rvalid(mem_rvalid),
        .mem_rdata(mem_rdata), .irq(irq)
    );

    function automatic logic [31:0] pat(input int a);
        return (32'(a) * 32'h0100_0193) ^ 32'hA5A5_0000;
    endfunction

    always @(posedge clk) begin
        if (rq_cnt != 0) rq_cnt <= rq_cnt - 1;
        if (mem_req && mem_gnt) begin
            if (mem_we) begin
                mem[mem_addr[10:0]] <= mem_wdata;
                wlog[wlog_n[9:0]]   <= mem_addr;
                wlog_n              <= wlog_n + 1;
            end else begin
                rq_addr <= mem_addr;
                rq_cnt  <= 1 + int'($urandom % 2);
            end
        end
    end

    always @(negedge clk) begin
        mem_gnt    <= ($urandom % 4) != 0;
        mem_rvalid <= (rq_cnt == 1);
        mem_rdata  <= pat(int'(rq_addr));
    end

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic cfg_wr(input int idx, input logic [2:0] fld, input logic [31:0] d, output logic err);
        @(negedge clk);
        cfg_req = 1'b1; cfg_idx = idx[2:0]; cfg_field = fld; cfg_wdata = d;
        @(negedge clk);
        cfg_req = 1'b0;
        chk(cfg_ack === 1'b1, "R2 ack", 32'(cfg_ack), 1);
        err = cfg_err;
    endtask

    task automatic prog(input int idx, input int own, input int src, input int dst,
                        input int cnt, input int per, input bit en);
        logic e;
        cfg_wr(idx, 3'd0, 32'(src), e);
        cfg_wr(idx, 3'd1, 32'(dst), e);
        cfg_wr(idx, 3'd2, 32'(cnt), e);
        cfg_wr(idx, 3'd3, 32'(per), e);
        cfg_wr(idx, 3'd4, 32'((own << 1) | int'(en)), e);
        chk(e == 1'b0, "R6 free slot accepted", 32'(e), 0);
    endtask

    task automatic wait_irq(input int b, input string tag);
        int n = 0;
        while (irq[b] !== 1'b1 && n < 3000) begin
            @(negedge clk);
            n++;
        end
        chk(irq[b] === 1'b1, tag, 32'(irq), 32'(1 << b));
    endtask

    task automatic clr_irq(input logic [31:0] m);
        logic e;
        cfg_wr(0, 3'd7, m, e);
    endtask

    task automatic pulse_tick();
        @(negedge clk); tick = 1'b1;
        @(negedge clk); tick = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    function automatic int writes_to(input int a);
        int c = 0;
        for (int i = 0; i < wlog_n; i++) if (int'(wlog[i]) == a) c++;
        return c;
    endfunction

    function automatic int first_write(input int a);
        for (int i = 0; i < wlog_n; i++) if (int'(wlog[i]) == a) return i;
        return -1;
    endfunction

    initial begin
        repeat (150000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        logic e;
        int   n0, r1, r2, run;
        void'($urandom(32'd11));
        idle(3);
        // R1 reset state
        chk(irq == 4'b0, "R1 irq", 32'(irq), 0);
        chk(mem_req == 1'b0, "R1 mem_req", 32'(mem_req), 0);
        chk(cfg_ack == 1'b0, "R1 cfg_ack", 32'(cfg_ack), 0);
        @(negedge clk); rst_n = 1'b1;
        idle(2);
        chk(irq == 4'b0 && mem_req == 1'b0, "R1 after release", 32'({irq, mem_req}), 0);

        // R3 one-shot copy of 5 words, owner 1
        n0 = wlog_n;
        prog(0, 1, 10, 300, 5, 0, 1'b1);
        wait_irq(1, "R5 owner1 set");
        for (int i = 0; i < 5; i++)
            chk(mem[300 + i] == pat(10 + i), "R3 copied word", mem[300 + i], pat(10 + i));
        chk(writes_to(305) == 0, "R3 no write past end", 32'(writes_to(305)), 0);
        chk(wlog_n - n0 == 5, "R3 write count", 32'(wlog_n - n0), 5);
        chk(int'(wlog[n0]) == 300 && int'(wlog[n0 + 4]) == 304, "R3 ascending", 32'(wlog[n0]), 300);
        // R3 one-shot does not rerun on ticks
        pulse_tick(); pulse_tick(); idle(30);
        chk(wlog_n - n0 == 5, "R3 one-shot stays off", 32'(wlog_n - n0), 5);

        // R5 clear: zero bits have no effect, one bits clear
        clr_irq(32'h0000_0004);
        chk(irq == 4'b0010, "R5 clear unrelated bit", 32'(irq), 32'h2);
        clr_irq(32'h0000_0002);
        chk(irq == 4'b0000, "R5 clear owner bit", 32'(irq), 0);

        // R4 zero-length descriptor
        n0 = wlog_n;
        prog(4, 2, 50, 900, 0, 0, 1'b1);
        wait_irq(2, "R4 zero length completes");
        idle(5);
        chk(wlog_n == n0, "R4 no memory write", 32'(wlog_n - n0), 0);
        clr_irq(32'h4);

        // R6 write to busy slot is rejected and leaves it unchanged
        prog(2, 0, 20, 400, 20, 0, 1'b1);
        while (mem_req !== 1'b1) @(negedge clk);
        cfg_wr(2, 3'd0, 32'd123, e);
        chk(e == 1'b1, "R6 busy slot err", 32'(e), 1);
        cfg_wr(3, 3'd0, 32'd77, e);
        chk(e == 1'b0, "R6 other slot ok", 32'(e), 0);
        cfg_wr(2, 3'd5, 32'd0, e);
        chk(e == 1'b1, "R6 busy slot any field", 32'(e), 1);
        wait_irq(0, "R5 owner0 set");
        clr_irq(32'h1);
        cfg_wr(2, 3'd1, 32'd500, e);
        cfg_wr(2, 3'd4, 32'h1, e);
        wait_irq(0, "R6 rerun done");
        chk(mem[500] == pat(20), "R6 source kept", mem[500], pat(20));
        chk(mem[419] == pat(39), "R3 last word long copy", mem[419], pat(39));
        clr_irq(32'hF);

        // R7 round robin: serve slot 3, then slots 1 and 5 ready; 5 goes first
        prog(3, 3, 60, 600, 20, 0, 1'b1);
        while (mem_req !== 1'b1) @(negedge clk);
        prog(1, 1, 70, 700, 1, 0, 1'b1);
        prog(5, 2, 71, 710, 1, 0, 1'b1);
        wait_irq(1, "R7 slot1 done");
        wait_irq(2, "R7 slot5 done");
        r1 = first_write(700); r2 = first_write(710);
        chk(r2 >= 0 && r1 > r2, "R7 order after slot3", 32'(r2), 32'(r1));
        chk(first_write(619) < r2, "R7 no interleave", 32'(first_write(619)), 32'(r2));
        chk(mem[700] == pat(70) && mem[710] == pat(71), "R7 data", mem[710], pat(71));
        clr_irq(32'hF);

        // R8 periodic descriptor, period 3
        prog(6, 3, 30, 800, 1, 3, 1'b1);
        wait_irq(3, "R8 first run");
        clr_irq(32'h8);
        pulse_tick(); pulse_tick(); idle(20);
        chk(writes_to(800) == 1, "R8 not yet", 32'(writes_to(800)), 1);
        pulse_tick(); idle(20);
        chk(writes_to(800) == 2, "R8 third tick", 32'(writes_to(800)), 2);
        chk(irq[3] == 1'b1, "R8 irq on rerun", 32'(irq), 32'h8);
        pulse_tick(); pulse_tick(); pulse_tick(); idle(20);
        chk(writes_to(800) == 3, "R8 reload", 32'(writes_to(800)), 3);
        cfg_wr(6, 3'd4, 32'h6, e);
        pulse_tick(); pulse_tick(); pulse_tick(); pulse_tick(); idle(20);
        chk(writes_to(800) == 3, "R8 disabled", 32'(writes_to(800)), 3);
        clr_irq(32'hF);

        // R3/R5 random one-shot transfers
        for (int r = 0; r < 12; r++) begin
            int idx = int'($urandom % 8);
            int own = int'($urandom % 4);
            int src = int'($urandom % 200);
            int cnt = 1 + int'($urandom % 6);
            int dst = 1200 + r * 8;
            n0 = wlog_n;
            prog(idx, own, src, dst, cnt, 0, 1'b1);
            wait_irq(own, "R5 random owner");
            run = 1;
            for (int i = 0; i < cnt; i++)
                if (mem[dst + i] != pat(src + i)) run = 0;
            chk(run == 1, "R3 random copy", 32'(run), 1);
            chk(wlog_n - n0 == cnt, "R3 random count", 32'(wlog_n - n0), 32'(cnt));
            clr_irq(32'hF);
            chk(irq == 4'b0, "R5 random clear", 32'(irq), 0);
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule